// File: doc/BRIEF.md
# Host Serial ADC Read Controller

This block sits in the system clock domain and runs a 12-bit serial-output converter. It drives the converter's active-low chip select, its serial clock and its power-down pin. It also shifts in the converter's data line and presents each finished 12-bit sample as a one-cycle valid pulse with its data. The serial clock comes from a divider of the system clock. The chip-select setup delay and the power-up settling delay are given in nanoseconds and converted to system-clock counts when the block is elaborated.

Two modes are supported. In single-shot mode, each request produces one framed conversion, and chip select goes high again once the frame ends. In continuous mode, chip select stays low and frames follow each other, with one idle clock period between them. A rising edge on the converter's busy flag re-synchronises the bit position, so a clock pulse that the converter missed corrupts at most one sample. Each frame carries four leading bits that must be zero. If they are not, the sample is rejected and an error pulse is raised. A host shutdown request ends the current frame at once and restarts the settling wait.

Top module: `serial_adc_host`

## Requirements
- R1: While reset is held and on the first cycle after it, `adc_cs_n` is 1, `adc_sclk` is 0, `adc_shdn` is 0, `result_valid` and `frame_err` are 0, and `busy` is 1 (settling wait).
- R2: From a falling edge of `adc_cs_n` to the first rising edge of `adc_sclk` there are exactly SETUP_CYC + HALF_DIV system clocks. SETUP_CYC = ceil(CS_SETUP_NS·CLK_HZ/1e9), with a minimum of 1.
- R3: `adc_cs_n` does not fall until at least PWR_CYC = ceil(PWRUP_NS·CLK_HZ/1e9) system clocks have passed since reset release or since shutdown release.
- R4: A frame is 16 rising edges of `adc_sclk`, and `adc_dout` is sampled on each rising edge. The first four bits are leading bits. The last 12 bits are the sample, MSB first. A good frame gives one `result_valid` pulse carrying those 12 bits on `result_data`.
- R5: If any leading bit is 1, `frame_err` pulses for one cycle and `result_valid` stays low for that frame.
- R6: In single-shot mode, `start` in the idle state begins exactly one frame, and `adc_cs_n` returns high after the frame ends. `start` has no effect while `busy` is 1.
- R7: In continuous mode (`mode_cont`=1), `adc_cs_n` stays low across frames. Each frame occupies 17 `adc_sclk` periods (16 bits plus one idle period), so results arrive every 34·HALF_DIV system clocks.
- R8: While `shdn_req` is 1, `adc_shdn` is 1 (one register later), `adc_cs_n` is 1 and `adc_sclk` is 0. A frame in progress is dropped with neither a `result_valid` nor a `frame_err` pulse.
- R9: In continuous mode, a rising edge of `adc_status` (after a two-flop synchroniser) resets the bit position to the first leading bit. After a missed converter clock, results are correct again from the second frame onward.
- R10: `adc_sclk` stays high for HALF_DIV = ceil(CLK_HZ/(2·SCLK_HZ)) system clocks and stays low for HALF_DIV system clocks between rising edges.
- R11: When `mode_cont` goes to 0 in continuous mode, the frame in progress completes, `adc_cs_n` returns high, and no further frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_cont | input | 1 | 1 = continuous conversions, 0 = single-shot |
| start | input | 1 | Single-shot request, accepted only when idle |
| shdn_req | input | 1 | Host request to power the converter down |
| adc_dout | input | 1 | Serial data from converter |
| adc_status | input | 1 | Converter busy flag, high during conversion |
| adc_cs_n | output | 1 | Active-low chip select to converter |
| adc_sclk | output | 1 | Serial clock to converter |
| adc_shdn | output | 1 | Power-down pin to converter |
| busy | output | 1 | Controller not idle |
| result_valid | output | 1 | One-cycle pulse: new sample on result_data |
| result_data | output | DATA_W | Captured sample |
| frame_err | output | 1 | One-cycle pulse: nonzero leading bits, sample dropped |

## Verification
The embedded properties check the following on every cycle:
- Chip-select setup before the first clock edge, and the settling window before any chip-select fall.
- The exact high time of each serial clock pulse.
- That results and errors never coincide and occur only on a sampling edge.
- That shutdown keeps the converter deselected.
- That continuous mode holds chip select low.
- That a status edge clears the bit position.

Only the bench scenarios can show data correctness against a converter model:
- Bit order and leading-bit rejection.
- That a busy-time request is ignored.
- Recovery after a dropped converter clock.
- That a shutdown mid-frame yields no output.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

  typedef enum logic [1:0] {
    ST_PWR   = 2'd0,
    ST_IDLE  = 2'd1,
    ST_SETUP = 2'd2,
    ST_FRAME = 2'd3
  } seq_state_t;

  // Rounded-up division, never below one count.
  function automatic int unsigned ceil_div(input longint unsigned num,
                                           input longint unsigned den);
    longint unsigned q;
    q = (num + den - 64'd1) / den;
    if (q == 64'd0) q = 64'd1;
    return 32'(q);
  endfunction

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int unsigned HALF_DIV = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk,
  output logic rise_p,
  output logic fall_p
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] ph;
  logic          wrap;

  assign wrap   = (ph == CW'(HALF_DIV - 1));
  assign rise_p = run & wrap & ~sclk;
  assign fall_p = run & wrap & sclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      ph   <= '0;
      sclk <= 1'b0;
    end else if (wrap) begin
      ph   <= '0;
      sclk <= ~sclk;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  // Checker: high time of each natural clock pulse
  logic [CW:0] hi_len;
  always_ff @(posedge clk) begin
    if (rst || !sclk) hi_len <= '0;
    else              hi_len <= hi_len + 1'b1;
  end

  assert_sclk_high_R10: assert property (@(posedge clk) disable iff (rst)
    ($fell(sclk) && $past(fall_p)) |-> (hi_len == (CW+1)'(HALF_DIV)));

  assert_sclk_stop_R10: assert property (@(posedge clk) disable iff (rst)
    !run |=> !sclk);

endmodule

// File: rtl/adc_frame_rx.sv
module adc_frame_rx #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned LEAD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              cont,
  input  logic              rise_p,
  input  logic              sdata,
  input  logic              status_in,
  output logic              frame_last,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_err
);
  localparam int unsigned FRAME_W = DATA_W + LEAD_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-2:0] shreg;
  logic [FRAME_W-1:0] word;
  logic [2:0]         st_sync;
  logic               st_rise;

  assign word       = {shreg, sdata};
  assign st_rise    = st_sync[1] & ~st_sync[2];
  assign frame_last = (bit_cnt == CNT_W'(FRAME_W));

  always_ff @(posedge clk) begin
    if (rst) st_sync <= '0;
    else     st_sync <= {st_sync[1:0], status_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
      if (!active) begin
        bit_cnt <= '0;
      end else if (cont && st_rise) begin
        bit_cnt <= '0;                       // re-align on new conversion
      end else if (rise_p) begin
        if (frame_last) begin
          if (cont) bit_cnt <= '0;           // idle period between frames
        end else begin
          shreg   <= word[FRAME_W-2:0];
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CNT_W'(FRAME_W - 1)) begin
            if (|word[FRAME_W-1:DATA_W]) begin
              rx_err <= 1'b1;
            end else begin
              rx_valid <= 1'b1;
              rx_data  <= word[DATA_W-1:0];
            end
          end
        end
      end
    end
  end

  assert_no_valid_and_err_R5: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid && rx_err));

  assert_result_on_edge_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_valid || rx_err) |-> $past(rise_p && active));

  assert_status_realign_R9: assert property (@(posedge clk) disable iff (rst)
    (active && cont && st_rise) |=> (bit_cnt == '0));

  assert_count_range_R4: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(FRAME_W));

endmodule

// File: rtl/adc_seq.sv
module adc_seq import adc_host_pkg::*; #(
  parameter int unsigned SETUP_CYC = 9,
  parameter int unsigned PWR_CYC   = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic mode_cont,
  input  logic shdn_req,
  input  logic fall_p,
  input  logic frame_last,
  output logic cs_n,
  output logic shdn_o,
  output logic run,
  output logic busy
);
  localparam int unsigned TMAX = (PWR_CYC > SETUP_CYC) ? PWR_CYC : SETUP_CYC;
  localparam int unsigned TW   = $clog2(TMAX + 1);

  seq_state_t    st;
  logic [TW-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_PWR;
      tcnt   <= '0;
      cs_n   <= 1'b1;
      shdn_o <= 1'b0;
    end else begin
      shdn_o <= shdn_req;
      if (shdn_req) begin
        st   <= ST_PWR;
        tcnt <= '0;
        cs_n <= 1'b1;
      end else begin
        unique case (st)
          ST_PWR: begin
            if (tcnt == TW'(PWR_CYC - 1)) begin
              st   <= ST_IDLE;
              tcnt <= '0;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_IDLE: begin
            if (start || mode_cont) begin
              st   <= ST_SETUP;
              cs_n <= 1'b0;
              tcnt <= '0;
            end
          end
          ST_SETUP: begin
            if (tcnt == TW'(SETUP_CYC - 1)) begin
              st   <= ST_FRAME;
              tcnt <= '0;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_FRAME: begin
            if (fall_p && frame_last && !mode_cont) begin
              st   <= ST_IDLE;
              cs_n <= 1'b1;
            end
          end
          default: st <= ST_PWR;
        endcase
      end
    end
  end

  assign run  = (st == ST_FRAME) && !shdn_req;
  assign busy = (st != ST_IDLE);

  // Checker: cycles since the power-down pin was released
  logic [TW:0] since_rel;
  always_ff @(posedge clk) begin
    if (rst || shdn_o)                         since_rel <= '0;
    else if (since_rel != (TW+1)'(PWR_CYC))    since_rel <= since_rel + 1'b1;
  end

  assert_settle_before_select_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (since_rel >= (TW+1)'(PWR_CYC)));

  assert_shdn_deselects_R8: assert property (@(posedge clk) disable iff (rst)
    shdn_o |-> cs_n);

  assert_cont_keeps_select_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FRAME && mode_cont && !shdn_req) |=> !cs_n);

endmodule

// File: rtl/serial_adc_host.sv
module serial_adc_host import adc_host_pkg::*; #(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned SCLK_HZ     = 4_000_000,
  parameter int unsigned CS_SETUP_NS = 90,
  parameter int unsigned PWRUP_NS    = 20_000,
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned LEAD_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_cont,
  input  logic              start,
  input  logic              shdn_req,
  input  logic              adc_dout,
  input  logic              adc_status,
  output logic              adc_cs_n,
  output logic              adc_sclk,
  output logic              adc_shdn,
  output logic              busy,
  output logic              result_valid,
  output logic [DATA_W-1:0] result_data,
  output logic              frame_err
);
  localparam int unsigned HALF_DIV  = ceil_div(64'(CLK_HZ), 64'(SCLK_HZ) * 64'd2);
  localparam int unsigned SETUP_CYC = ceil_div(64'(CS_SETUP_NS) * 64'(CLK_HZ), 64'd1_000_000_000);
  localparam int unsigned PWR_CYC   = ceil_div(64'(PWRUP_NS) * 64'(CLK_HZ), 64'd1_000_000_000);
  localparam int unsigned SW        = $clog2(SETUP_CYC + 1) + 1;

  logic run, rise_p, fall_p, frame_last;

  adc_seq #(
    .SETUP_CYC (SETUP_CYC),
    .PWR_CYC   (PWR_CYC)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .mode_cont  (mode_cont),
    .shdn_req   (shdn_req),
    .fall_p     (fall_p),
    .frame_last (frame_last),
    .cs_n       (adc_cs_n),
    .shdn_o     (adc_shdn),
    .run        (run),
    .busy       (busy)
  );

  adc_sclk_gen #(
    .HALF_DIV (HALF_DIV)
  ) u_sclk (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .sclk   (adc_sclk),
    .rise_p (rise_p),
    .fall_p (fall_p)
  );

  adc_frame_rx #(
    .DATA_W (DATA_W),
    .LEAD_W (LEAD_W)
  ) u_rx (
    .clk        (clk),
    .rst        (rst),
    .active     (run),
    .cont       (mode_cont),
    .rise_p     (rise_p),
    .sdata      (adc_dout),
    .status_in  (adc_status),
    .frame_last (frame_last),
    .rx_valid   (result_valid),
    .rx_data    (result_data),
    .rx_err     (frame_err)
  );

  // Checker: cycles chip select has been low
  logic [SW-1:0] cs_low_cnt;
  always_ff @(posedge clk) begin
    if (rst || adc_cs_n)                       cs_low_cnt <= '0;
    else if (cs_low_cnt != SW'(SETUP_CYC))     cs_low_cnt <= cs_low_cnt + 1'b1;
  end

  assert_select_setup_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_sclk) |-> (cs_low_cnt >= SW'(SETUP_CYC)));

  assert_clock_idle_when_deselected_R1: assert property (@(posedge clk) disable iff (rst)
    adc_cs_n |-> !adc_sclk);

endmodule

// File: tb/serial_adc_host_tb.sv
module serial_adc_host_tb;
  localparam int HALF  = 4;     // 100 MHz / (2 * 12.5 MHz)
  localparam int SETUP = 9;     // 90 ns at 10 ns
  localparam int PWR   = 50;    // 500 ns at 10 ns

  // {expect_error, 16-bit frame}
  localparam logic [16:0] VEC [7] = '{
    17'h0_0ABC, 17'h0_0000, 17'h0_0FFF, 17'h0_0801,
    17'h1_8123, 17'h1_1FFF, 17'h0_0555
  };

  logic clk = 1'b0, rst = 1'b1, mode_cont = 1'b0, start = 1'b0, shdn_req = 1'b0;
  logic adc_dout = 1'b0, adc_status = 1'b0;
  logic adc_cs_n, adc_sclk, adc_shdn, busy, result_valid, frame_err;
  logic [11:0] result_data;

  always #5 clk = ~clk;

  serial_adc_host #(
    .CLK_HZ(100_000_000), .SCLK_HZ(12_500_000), .CS_SETUP_NS(90),
    .PWRUP_NS(500), .DATA_W(12), .LEAD_W(4)
  ) u_dut (
    .clk(clk), .rst(rst), .mode_cont(mode_cont), .start(start), .shdn_req(shdn_req),
    .adc_dout(adc_dout), .adc_status(adc_status), .adc_cs_n(adc_cs_n),
    .adc_sclk(adc_sclk), .adc_shdn(adc_shdn), .busy(busy),
    .result_valid(result_valid), .result_data(result_data), .frame_err(frame_err)
  );

  int errors = 0, checks = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Converter model
  logic [15:0] mword = 16'h0000;
  logic [15:0] cur = 16'h0000;
  bit skip_req = 0, skip_done = 0;
  int midx = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0;
  always @(adc_cs_n or adc_sclk) begin
    if (adc_cs_n) begin
      adc_status <= 1'b0; adc_dout <= 1'b0; midx = 0;
    end else if (prev_cs) begin
      midx = 0; cur = mword; adc_status <= 1'b1; adc_dout <= mword[15];
    end else if (prev_sclk && !adc_sclk) begin
      if (skip_req && !skip_done) skip_done = 1;
      else begin
        midx++;
        if (midx < 16) adc_dout <= cur[15-midx];
        else if (midx == 16) begin adc_status <= 1'b0; adc_dout <= 1'b0; end
        else begin midx = 0; cur = mword; adc_status <= 1'b1; adc_dout <= mword[15]; end
      end
    end
    prev_cs = adc_cs_n; prev_sclk = adc_sclk;
  end

  // Monitor
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  int nval = 0, nerr = 0, ncsf = 0, t_csf = 0, t_rise1 = 0, t_lrise = 0, hi_len = 0;
  int t_vlast = 0, t_vprev = 0;
  bit want_rise = 0;
  logic [11:0] last_data = '0;
  logic mcs = 1'b1, msclk = 1'b0;
  bit done = 0;
  always @(negedge clk) begin
    if (result_valid) begin nval++; last_data = result_data; t_vprev = t_vlast; t_vlast = cyc; end
    if (frame_err) nerr++;
    if (mcs && !adc_cs_n) begin ncsf++; t_csf = cyc; want_rise = 1; end
    if (!msclk && adc_sclk) begin
      if (want_rise) begin t_rise1 = cyc; want_rise = 0; end
      t_lrise = cyc;
    end
    if (msclk && !adc_sclk) hi_len = cyc - t_lrise;
    mcs = adc_cs_n; msclk = adc_sclk;
    if (cyc > 100000 && !done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wait_idle(input int lim);
    int n = 0;
    while (busy && n < lim) begin @(negedge clk); n++; end
  endtask

  task automatic wait_events(input int target, input int lim);
    int n = 0;
    while ((nval + nerr) < target && n < lim) begin @(negedge clk); n++; end
  endtask

  task automatic single(input logic [15:0] w);
    mword = w;
    start = 1'b1; @(negedge clk); start = 1'b0; @(negedge clk);
    wait_idle(1000);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int v0, e0, c0, t0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(adc_cs_n == 1'b1, "R1 cs_n", adc_cs_n, 1);
    chk(adc_sclk == 1'b0, "R1 sclk", adc_sclk, 0);
    chk(adc_shdn == 1'b0, "R1 shdn", adc_shdn, 0);
    chk(!result_valid && !frame_err, "R1 outputs", {result_valid, frame_err}, 0);
    chk(busy == 1'b1, "R1 busy", busy, 1);
    rst = 1'b0; t0 = cyc; start = 1'b1;
    @(negedge clk);
    chk(adc_cs_n == 1'b1 && busy == 1'b1, "R1 after release", {adc_cs_n, busy}, 3);
    while (ncsf == 0 && cyc < t0 + 500) @(negedge clk);
    start = 1'b0;
    // R3: settling wait after reset
    chk(t_csf - t0 >= PWR, "R3 reset wait", t_csf - t0, PWR + 1);
    wait_idle(1000);
    // R2: setup and R10: high time
    chk(t_rise1 - t_csf == SETUP + HALF, "R2 setup", t_rise1 - t_csf, SETUP + HALF);
    chk(hi_len == HALF, "R10 high time", hi_len, HALF);
    repeat (3) @(negedge clk);

    // Vector table (R4, R5)
    for (int i = 0; i < 7; i++) begin
      v0 = nval; e0 = nerr;
      single(VEC[i][15:0]);
      if (VEC[i][16]) begin
        chk(nerr - e0 == 1 && nval == v0, "R5 leading bits", nerr - e0, 1);
      end else begin
        chk(nval - v0 == 1 && nerr == e0, "R4 count", nval - v0, 1);
        chk(last_data == VEC[i][11:0], "R4 data", last_data, VEC[i][11:0]);
      end
      chk(adc_cs_n == 1'b1, "R6 deselect after frame", adc_cs_n, 1);
      chk(t_rise1 - t_csf == SETUP + HALF, "R2 setup per frame", t_rise1 - t_csf, SETUP + HALF);
    end

    // R6: start ignored while busy
    v0 = nval; c0 = ncsf; mword = 16'h0321;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_idle(1000);
    repeat (60) @(negedge clk);
    chk(ncsf - c0 == 1, "R6 one frame", ncsf - c0, 1);
    chk(nval - v0 == 1 && last_data == 12'h321, "R6 data", last_data, 12'h321);

    // R7: continuous mode
    mword = 16'h0A5C; v0 = nval; c0 = ncsf;
    mode_cont = 1'b1;
    wait_events(nval + nerr + 3, 3000);
    chk(nval - v0 == 3, "R7 count", nval - v0, 3);
    chk(last_data == 12'hA5C, "R7 data", last_data, 12'hA5C);
    chk(t_vlast - t_vprev == 34 * HALF, "R7 period", t_vlast - t_vprev, 34 * HALF);
    chk(ncsf - c0 == 1 && adc_cs_n == 1'b0, "R7 select held", ncsf - c0, 1);

    // R9: missed converter clock, then re-alignment
    mword = 16'h0C3A;
    wait_events(nval + nerr + 1, 2000);
    skip_req = 1;
    wait_events(nval + nerr + 3, 3000);
    chk(last_data == 12'hC3A, "R9 realigned", last_data, 12'hC3A);
    v0 = nval;
    wait_events(nval + nerr + 1, 2000);
    chk(nval - v0 == 1 && last_data == 12'hC3A, "R9 stays aligned", last_data, 12'hC3A);
    chk(t_vlast - t_vprev == 34 * HALF, "R9 period", t_vlast - t_vprev, 34 * HALF);

    // R11: leave continuous mode
    mode_cont = 1'b0;
    wait_idle(1000);
    @(negedge clk);
    chk(adc_cs_n == 1'b1, "R11 deselect", adc_cs_n, 1);
    v0 = nval; c0 = ncsf;
    repeat (200) @(negedge clk);
    chk(nval == v0 && ncsf == c0, "R11 no further frames", ncsf - c0, 0);

    // R8: shutdown mid-frame
    v0 = nval; e0 = nerr; mword = 16'h0123;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (60) @(negedge clk);
    shdn_req = 1'b1;
    repeat (3) @(negedge clk);
    chk(adc_shdn == 1'b1, "R8 shdn pin", adc_shdn, 1);
    chk(adc_cs_n == 1'b1 && adc_sclk == 1'b0, "R8 bus idle", {adc_cs_n, adc_sclk}, 2);
    repeat (150) @(negedge clk);
    chk(nval == v0 && nerr == e0, "R8 frame dropped", (nval - v0) + (nerr - e0), 0);
    c0 = ncsf;
    shdn_req = 1'b0; t0 = cyc; start = 1'b1;
    while (ncsf == c0 && cyc < t0 + 500) @(negedge clk);
    start = 1'b0;
    chk(t_csf - t0 >= PWR, "R3 wait after shutdown", t_csf - t0, PWR + 1);
    wait_idle(1000);
    repeat (3) @(negedge clk);
    chk(nval - v0 == 1 && last_data == 12'h123, "R8 resumes", last_data, 12'h123);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule